// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words. Each word has 1 sign bit, 8 exponent bits and 23 fraction bits, with an exponent bias of 127. A one-cycle pulse on `go` while the unit is idle captures both operands. The result sign is the exclusive-or of the operand signs. The exponent is the sum of the two biased exponents with one bias removed. The 24-bit significands, each with its hidden one restored, are multiplied by a shift-and-add engine that retires one multiplier bit per cycle.

When the product is complete it is normalized in a single step. It is then rounded to nearest with ties to even, checked against the exponent range and packed. The packed word and three exception flags are registered together, and `done` pulses for one cycle. Operands with a zero exponent field count as zero, so subnormal inputs are flushed. A result whose exponent falls to zero or below is also flushed to zero. Results keep their value until the next completion, so a client may sample them at leisure.

Top module: `fpmul_seq`

## Requirements
- R1: For two normal operands whose product is in range, `prod_word` holds the sign XOR, the exponent (ea + eb - 127) and the rounded fraction. Examples: 0x3F800000 x 0x3F800000 = 0x3F800000, 0x40000000 x 0x40400000 = 0x40C00000, 0xBFC00000 x 0x40000000 = 0xC0400000. No flag is raised.
- R2: When the 48-bit significand product has its top bit set, it is shifted right one place and the exponent is incremented. Example: 0x3FC00000 x 0x3FC00000 = 0x40100000.
- R3: Rounding is to nearest, with ties to even. If a rounded fraction carries out, the exponent is incremented. Examples: 0x3F800001 x 0x3FC00000 = 0x3FC00002 (tie, rounds up). 0x3F800003 x 0x3FC00000 = 0x3FC00004 (tie, stays). 0x3F800001 x 0x3F800001 = 0x3F800002 (below half). 0x3F800001 x 0x3FFFFFFE = 0x40000000 (carry).
- R4: If the final biased exponent is 255 or more, the result is a signed infinity (exponent all ones, fraction zero) and `flag_ovf` is set. Examples: 0x7F000000 x 0x40000000 = 0x7F800000. 0xFF000000 x 0x40000000 = 0xFF800000. 0x7F7FFFFF x 0x3F800001 = 0x7F800000. In contrast, 0x7F7FFFFF x 0x3F800000 = 0x7F7FFFFF with no flag.
- R5: If the final biased exponent is 0 or less, the result is a signed zero and `flag_udf` is set. Examples: 0x00800000 x 0x3F000000 = 0x00000000 and 0x80800000 x 0x3F000000 = 0x80000000, both with the flag. In contrast, 0x00800000 x 0x3F800000 = 0x00800000 with no flag.
- R6: An operand with exponent field 0 counts as zero, whatever its fraction. When it meets a finite operand, the result is a zero carrying the XOR sign, and no flag is raised. Example: 0x00000001 x 0x40000000 = 0x00000000.
- R7: An infinity (exponent 255, fraction 0) times a nonzero non-NaN operand gives an infinity carrying the XOR sign, with no flag raised.
- R8: Infinity times zero gives 0x7FC00000 with `flag_inv` set.
- R9: A NaN operand (exponent 255, fraction nonzero) gives 0x7FC00000 with no flag raised. This takes precedence over the infinity-times-zero case.
- R10: `done` is a one-cycle pulse, 25 clock cycles after the edge that sampled `go`. `prod_word` and the flags change only when `done` rises, and they hold their values afterwards.
- R11: A `go` pulse that arrives while a multiplication is in progress is ignored. It produces no extra `done`, and the pending result is not altered.
- R12: After reset, `done`, `prod_word` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start pulse, accepted only when idle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| prod_word | output | 32 | Packed product |
| done | output | 1 | One-cycle completion pulse |
| flag_ovf | output | 1 | Result exponent overflowed |
| flag_udf | output | 1 | Result flushed to zero by underflow |
| flag_inv | output | 1 | Infinity times zero |

## Verification
The hardest situations to reach from the ports are the rounding corners. These are an exact tie whose outcome depends on the kept fraction's lowest bit, and a round-up that carries out of the fraction and bumps the exponent. Each one needs an operand pair whose 48-bit product has a precise pattern below the kept bits. The stimulus uses significands of the form 1 + k·2^-23 against 1.5 or against 2 - 2^-22. This places the discarded half exactly, or just above it, at the guard position. The exponent boundaries are hit the same way: the largest finite value times one, and times one plus an ulp.

// File: rtl/fpm_pkg.sv
// Package: shared format constants and the unpacked-operand type for the
// single-precision multiplier. Assumes a 1/EXP_W/FRAC_W word layout.
package fpm_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int EXT_W   = EXP_W + 3;

    typedef struct packed {
        logic              sgn;
        logic [EXP_W-1:0]  ex;
        logic [SIG_W-1:0]  sig;
        logic              zro;
        logic              inf;
        logic              nan;
    } fpm_opnd_t;
endpackage

// File: rtl/fpm_unpack.sv
// Module: splits one packed word into its sign, exponent and significand
// (with the hidden one) and classifies it. A zero exponent field counts as
// zero, so subnormal inputs are flushed. Purely combinational.
module fpm_unpack
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fpm_opnd_t         opnd
);
    logic [EXP_W-1:0]  ex_f;
    logic [FRAC_W-1:0] fr_f;

    // field split and classification
    always_comb begin
        ex_f      = word[WORD_W-2 -: EXP_W];
        fr_f      = word[FRAC_W-1:0];
        opnd.sgn  = word[WORD_W-1];
        opnd.ex   = ex_f;
        opnd.zro  = (ex_f == '0);
        opnd.inf  = (ex_f == EXP_W'(EXP_MAX)) && (fr_f == '0);
        opnd.nan  = (ex_f == EXP_W'(EXP_MAX)) && (fr_f != '0);
        opnd.sig  = opnd.zro ? '0 : {1'b1, fr_f};
    end
endmodule

// File: rtl/fpm_sigmul.sv
// Module: iterative unsigned W x W multiplier. Each cycle it retires one
// multiplier bit (LSB first) by conditional add and right shift. A load
// starts W steps, and fin pulses one cycle after the last step. Assumes
// load is asserted only while run is low.
module fpm_sigmul #(
    parameter int W = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic           run,
    output logic           fin,
    output logic [2*W-1:0] prod
);
    localparam int CW = $clog2(W);

    logic [CW-1:0]  cnt;
    logic [W-1:0]   mc;
    logic [2*W-1:0] acc;
    logic [W:0]     psum;

    // partial sum of the upper half and the conditionally added multiplicand
    always_comb begin
        psum = {1'b0, acc[2*W-1:W]} + (acc[0] ? {1'b0, mc} : '0);
    end

    // step sequencing and accumulator update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            fin <= 1'b0;
            cnt <= '0;
            mc  <= '0;
            acc <= '0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                acc <= {{W{1'b0}}, mplier};
                mc  <= mcand;
                cnt <= '0;
                run <= 1'b1;
            end else if (run) begin
                acc <= {psum, acc[W-1:1]};
                cnt <= cnt + 1'b1;
                if (cnt == CW'(W - 1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    assign prod = acc;

    // R10
    fin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> !run);
    // R11
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= CW'(W - 1)));
endmodule

// File: rtl/fpm_normround.sv
// Module: takes the operand classes, the XOR sign, both biased exponents
// and the full significand product. It normalizes in one step, rounds to
// nearest even, range-checks and packs, and it also resolves the special
// operands. Combinational. Assumes the product comes from two significands
// that each have the hidden one set whenever the operand is normal.
module fpm_normround
    import fpm_pkg::*;
(
    input  logic                 sgn,
    input  logic [EXP_W-1:0]     ea,
    input  logic [EXP_W-1:0]     eb,
    input  logic [2*SIG_W-1:0]   prod,
    input  logic                 any_nan,
    input  logic                 any_inf,
    input  logic                 any_zro,
    output logic [WORD_W-1:0]    word,
    output logic                 ovf,
    output logic                 udf,
    output logic                 inv
);
    localparam logic signed [EXT_W-1:0] BIAS_S = EXT_W'(BIAS);
    localparam logic signed [EXT_W-1:0] MAX_S  = EXT_W'(EXP_MAX);
    localparam logic signed [EXT_W-1:0] ONE_S  = EXT_W'(1);
    localparam logic signed [EXT_W-1:0] ZERO_S = '0;
    localparam logic [WORD_W-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic signed [EXT_W-1:0] e0, e1, e2;
    logic [FRAC_W-1:0]       m;
    logic [FRAC_W:0]         mr;
    logic                    g, st, rnd, top;

    // exponent sum, one-step normalization, rounding and packing
    always_comb begin
        e0  = $signed({3'b000, ea}) + $signed({3'b000, eb}) - BIAS_S;
        top = prod[2*SIG_W-1];
        if (top) begin
            m  = prod[2*SIG_W-2 -: FRAC_W];
            g  = prod[SIG_W-1];
            st = |prod[SIG_W-2:0];
            e1 = e0 + ONE_S;
        end else begin
            m  = prod[2*SIG_W-3 -: FRAC_W];
            g  = prod[SIG_W-2];
            st = |prod[SIG_W-3:0];
            e1 = e0;
        end
        rnd = g & (st | m[0]);
        mr  = {1'b0, m} + (FRAC_W+1)'(rnd);
        e2  = mr[FRAC_W] ? (e1 + ONE_S) : e1;

        word = '0;
        ovf  = 1'b0;
        udf  = 1'b0;
        inv  = 1'b0;
        if (any_nan) begin
            word = QNAN;
        end else if (any_inf && any_zro) begin
            word = QNAN;
            inv  = 1'b1;
        end else if (any_inf) begin
            word = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (any_zro) begin
            word = {sgn, {(WORD_W-1){1'b0}}};
        end else if (e2 >= MAX_S) begin
            word = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            ovf  = 1'b1;
        end else if (e2 <= ZERO_S) begin
            word = {sgn, {(WORD_W-1){1'b0}}};
            udf  = 1'b1;
        end else begin
            word = {sgn, e2[EXP_W-1:0], mr[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/fpmul_seq.sv
// Module: top of the sequential single-precision multiplier. It captures
// the operands on an accepted go, runs the iterative significand product,
// then registers the packed result and the flags with a one-cycle done.
// Assumes go is a pulse; a go that arrives while busy is dropped.
module fpmul_seq
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [WORD_W-1:0] prod_word,
    output logic              done,
    output logic              flag_ovf,
    output logic              flag_udf,
    output logic              flag_inv
);
    fpm_opnd_t            opnd [2];
    logic [WORD_W-1:0]    ins  [2];
    logic                 busy, load, mrun, mfin;
    logic                 r_sgn, r_nan, r_inf, r_zro;
    logic [EXP_W-1:0]     r_ea, r_eb;
    logic [2*SIG_W-1:0]   mprod;
    logic [WORD_W-1:0]    nr_word;
    logic                 nr_ovf, nr_udf, nr_inv;

    assign ins[0] = op_a;
    assign ins[1] = op_b;
    assign load   = go && !busy;

    for (genvar i = 0; i < 2; i++) begin : g_unp
        fpm_unpack u_unp (.word(ins[i]), .opnd(opnd[i]));
    end

    fpm_sigmul #(.W(SIG_W)) u_mul (
        .clk(clk), .rst_n(rst_n), .load(load),
        .mcand(opnd[0].sig), .mplier(opnd[1].sig),
        .run(mrun), .fin(mfin), .prod(mprod)
    );

    fpm_normround u_nr (
        .sgn(r_sgn), .ea(r_ea), .eb(r_eb), .prod(mprod),
        .any_nan(r_nan), .any_inf(r_inf), .any_zro(r_zro),
        .word(nr_word), .ovf(nr_ovf), .udf(nr_udf), .inv(nr_inv)
    );

    // busy tracking and capture of operand classes on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            r_sgn <= 1'b0;
            r_nan <= 1'b0;
            r_inf <= 1'b0;
            r_zro <= 1'b0;
            r_ea  <= '0;
            r_eb  <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            r_sgn <= opnd[0].sgn ^ opnd[1].sgn;
            r_nan <= opnd[0].nan | opnd[1].nan;
            r_inf <= opnd[0].inf | opnd[1].inf;
            r_zro <= opnd[0].zro | opnd[1].zro;
            r_ea  <= opnd[0].ex;
            r_eb  <= opnd[1].ex;
        end else if (mfin) begin
            busy  <= 1'b0;
        end
    end

    // result registers, written once per completed product
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_word <= '0;
            done      <= 1'b0;
            flag_ovf  <= 1'b0;
            flag_udf  <= 1'b0;
            flag_inv  <= 1'b0;
        end else begin
            done <= mfin;
            if (mfin) begin
                prod_word <= nr_word;
                flag_ovf  <= nr_ovf;
                flag_udf  <= nr_udf;
                flag_inv  <= nr_inv;
            end
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (!done || 1'b1) && ($stable(prod_word) || done));
    // R4
    ovf_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ovf |-> (prod_word[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
    // R5
    udf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_udf |-> (prod_word[WORD_W-2:0] == '0));
    // R8
    inv_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_inv |-> (prod_word == {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}));
    // R8
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_ovf, flag_udf, flag_inv}));
    // R11
    busy_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrun |-> busy);
endmodule

// File: tb/fpmul_seq_tb.sv
`timescale 1ns/1ps
module fpmul_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [31:0] prod_word;
    logic        done, flag_ovf, flag_udf, flag_inv;

    int n_chk = 0;
    int n_fail = 0;
    int n_done = 0;
    int n_push = 0;
    bit finished = 0;

    logic [34:0] q_exp [$];
    string       q_tag [$];

    fpmul_seq u_dut (
        .clk(clk), .rst_n(rst_n), .go(go), .op_a(op_a), .op_b(op_b),
        .prod_word(prod_word), .done(done),
        .flag_ovf(flag_ovf), .flag_udf(flag_udf), .flag_inv(flag_inv)
    );

    always #2 clk = ~clk;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pop the expected item for every completion and compare
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_done++;
            if (q_exp.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R11: actual unexpected done expected no done");
            end else begin
                logic [34:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check(t, {29'd0, prod_word, flag_ovf, flag_udf, flag_inv},
                      {29'd0, e});
            end
        end
    end

    // driver: push expectation, pulse go, check latency, pulse width, hold
    task automatic run_vec(logic [31:0] a, logic [31:0] b, logic [31:0] res,
                           logic [2:0] flg, string tag);
        int lat;
        q_exp.push_back({res, flg});
        q_tag.push_back(tag);
        n_push++;
        op_a = a;
        op_b = b;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check("R10 latency", 64'(lat), 64'd25);
        @(negedge clk);
        check("R10 pulse", 64'(done), 64'd0);
        op_a = 32'h12345678;
        op_b = 32'h9ABCDEF0;
        @(negedge clk);
        check("R10 hold", 64'(prod_word), 64'(res));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", {59'd0, prod_word, done, flag_ovf, flag_udf, flag_inv} , 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_vec(32'h3F800000, 32'h3F800000, 32'h3F800000, 3'b000, "R1 1x1");
        run_vec(32'h40000000, 32'h40400000, 32'h40C00000, 3'b000, "R1 2x3");
        run_vec(32'hBFC00000, 32'h40000000, 32'hC0400000, 3'b000, "R1 sign");
        run_vec(32'h3FC00000, 32'h3FC00000, 32'h40100000, 3'b000, "R2 norm");
        run_vec(32'h3F800001, 32'h3FC00000, 32'h3FC00002, 3'b000, "R3 tie up");
        run_vec(32'h3F800003, 32'h3FC00000, 32'h3FC00004, 3'b000, "R3 tie even");
        run_vec(32'h3F800001, 32'h3F800001, 32'h3F800002, 3'b000, "R3 below half");
        run_vec(32'h3F800001, 32'h3FFFFFFE, 32'h40000000, 3'b000, "R3 carry");
        run_vec(32'h7F000000, 32'h40000000, 32'h7F800000, 3'b100, "R4 pos");
        run_vec(32'hFF000000, 32'h40000000, 32'hFF800000, 3'b100, "R4 neg");
        run_vec(32'h7F7FFFFF, 32'h3F800001, 32'h7F800000, 3'b100, "R4 edge");
        run_vec(32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 3'b000, "R4 max finite");
        run_vec(32'h00800000, 32'h3F000000, 32'h00000000, 3'b010, "R5 pos");
        run_vec(32'h80800000, 32'h3F000000, 32'h80000000, 3'b010, "R5 neg");
        run_vec(32'h00800000, 32'h3F800000, 32'h00800000, 3'b000, "R5 min normal");
        run_vec(32'h00000000, 32'h40400000, 32'h00000000, 3'b000, "R6 zero");
        run_vec(32'h80000000, 32'h40400000, 32'h80000000, 3'b000, "R6 neg zero");
        run_vec(32'h00000001, 32'h40000000, 32'h00000000, 3'b000, "R6 subnormal");
        run_vec(32'h7F800000, 32'h40000000, 32'h7F800000, 3'b000, "R7 inf");
        run_vec(32'h7F800000, 32'hC0000000, 32'hFF800000, 3'b000, "R7 neg inf");
        run_vec(32'hFF800000, 32'h7F800000, 32'hFF800000, 3'b000, "R7 inf x inf");
        run_vec(32'h7F800000, 32'h00000000, 32'h7FC00000, 3'b001, "R8 inf x 0");
        run_vec(32'h80000000, 32'hFF800000, 32'h7FC00000, 3'b001, "R8 0 x -inf");
        run_vec(32'h7FC00001, 32'h3F800000, 32'h7FC00000, 3'b000, "R9 nan");
        run_vec(32'h00000000, 32'h7F800001, 32'h7FC00000, 3'b000, "R9 nan x 0");

        // R11: second go while busy must be dropped
        q_exp.push_back({32'h40C00000, 3'b000});
        q_tag.push_back("R11 first kept");
        n_push++;
        op_a = 32'h40000000;
        op_b = 32'h40400000;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (5) @(negedge clk);
        op_a = 32'h7F000000;
        op_b = 32'h40000000;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (60) @(negedge clk);
        check("R11 done count", 64'(n_done), 64'(n_push));

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule